// File: doc/BRIEF.md
# Operand Address Unit

This block computes the effective memory address for a register-plus-memory add operation, fetches the operand through a synchronous read port, and returns the sum with the destination register. One of ten addressing modes is selected by a 4-bit code. Two modes need no memory access at all: the operand is either a second register or a constant. The remaining modes build an address from a constant field, a base register and an index register, alone or in combination.

Memory-indirect mode chains two dependent reads: the word returned by the first read becomes the address of the second. Two further modes also update the base register. The post-increment mode reads at the base and then advances it by the element size. The pre-decrement mode steps the base back first and reads at the new value. The new base value is presented on a writeback strobe together with the final result. The element size is a parameter, and the scaled mode multiplies the index by it with a shift.

The unit takes one operation at a time. It captures every operand at the start strobe, so the issuing logic may change its inputs as soon as the strobe has been taken.

Top module: `operand_addr_unit`

## Requirements
- R1: After a synchronous reset, `done`, `mem_rd_en` and `base_wr_en` are low.
- R2: Mode 0 (register) and mode 1 (constant) issue no memory read. `done` is high in the cycle after the start cycle, with `operand` equal to `base_val` (mode 0) or `konst` (mode 1).
- R3: Every single-read mode raises `mem_rd_en` for exactly one cycle, in the cycle after the start cycle, and raises `done` two cycles after that read cycle. The single-read modes are 2, 3, 4, 5, 7, 8 and 9.
- R4: The read address for each single-read mode is as follows. Mode 2 reads at `konst + base_val`. Mode 3 reads at `base_val`. Mode 4 reads at `base_val + idx_val`. Mode 5 reads at `konst`.
- R5: Mode 6 (memory indirect) first reads at `base_val`, then reads at the word returned by that read. The two reads are two cycles apart, `done` comes two cycles after the second read, and `operand` is the second returned word.
- R6: Mode 7 (post-increment) reads at `base_val`. In the `done` cycle, `base_wr_val` is `base_val + ELEM_BYTES`.
- R7: Mode 8 (pre-decrement) reads at `base_val - ELEM_BYTES`, wrapping modulo 2^XLEN. In the `done` cycle, `base_wr_val` is that same value.
- R8: Mode 9 (scaled) reads at `konst + base_val + idx_val * ELEM_BYTES`.
- R9: `base_wr_en` is high only in the `done` cycle of modes 7 and 8, and stays low in every other mode.
- R10: In the `done` cycle, `result` equals the destination value sampled at start plus `operand`. For the memory modes, `operand` is the last word read.
- R11: A start strobe that arrives while an operation is in progress is ignored. It produces no extra read and no extra `done`, and the running operation's result is unchanged.
- R12: Codes 10 to 15 are reserved. A start with a reserved code issues no read, raises no `done`, and leaves the unit idle for the next operation.
- R13: All inputs are sampled in the start cycle. Changing them afterwards does not affect the address, the result or the writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the values on the other inputs |
| mode | input | 4 | Addressing mode code (0 to 9; 10 to 15 are reserved) |
| konst | input | XLEN | Constant, displacement or absolute address field |
| dst_val | input | XLEN | Destination register value (first addend) |
| base_val | input | XLEN | Base register value |
| idx_val | input | XLEN | Index register value |
| mem_rd_en | output | 1 | Read request to memory, one cycle per read |
| mem_addr | output | XLEN | Read address |
| mem_rdata | input | XLEN | Read data, valid in the cycle after the request |
| done | output | 1 | Result valid, one-cycle pulse |
| operand | output | XLEN | Fetched or selected operand |
| result | output | XLEN | `dst_val` plus operand |
| base_wr_en | output | 1 | Base-register writeback strobe |
| base_wr_val | output | XLEN | New base-register value |

## Verification
The hardest situation to reach is a start strobe landing in the middle of a memory-indirect operation. At that point the first read has already returned, and the unit is about to reissue using the returned word. A stray accept there would corrupt the address of the second read or produce a second `done`. The bench runs a memory-indirect operation and pulses `start` again with a register-mode request in exactly that cycle. It then checks that only two reads were issued, that their addresses are correct, and that a single `done` carries the indirect result. Every operation also scrambles all inputs right after the start cycle, so any logic that reads live inputs instead of captured values shows up.

// File: rtl/oau_pkg.sv
package oau_pkg;

  typedef logic [3:0] amode_t;

  localparam amode_t MODE_REG    = 4'd0;
  localparam amode_t MODE_IMM    = 4'd1;
  localparam amode_t MODE_DISP   = 4'd2;
  localparam amode_t MODE_RIND   = 4'd3;
  localparam amode_t MODE_INDEX  = 4'd4;
  localparam amode_t MODE_ABS    = 4'd5;
  localparam amode_t MODE_MIND   = 4'd6;
  localparam amode_t MODE_AINC   = 4'd7;
  localparam amode_t MODE_ADEC   = 4'd8;
  localparam amode_t MODE_SCALED = 4'd9;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_TAKE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/oau_agen.sv
module oau_agen
  import oau_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ELEM_BYTES = 4
) (
  input  amode_t            mode,
  input  logic [XLEN-1:0]   konst,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   idx_val,
  output logic              mode_ok,
  output logic              needs_mem,
  output logic              is_ind,
  output logic [XLEN-1:0]   addr,
  output logic [XLEN-1:0]   imm_operand,
  output logic              wb_req,
  output logic [XLEN-1:0]   wb_val
);

  localparam int              SHIFT = $clog2(ELEM_BYTES);
  localparam logic [XLEN-1:0] STEP  = XLEN'(ELEM_BYTES);

  logic [XLEN-1:0] scaled_idx;

  generate
    if (SHIFT == 0) begin : g_noscale
      assign scaled_idx = idx_val;
    end else begin : g_scale
      assign scaled_idx = {idx_val[XLEN-1-SHIFT:0], {SHIFT{1'b0}}};
    end
  endgenerate

  always_comb begin
    mode_ok     = (mode <= MODE_SCALED);
    needs_mem   = 1'b1;
    is_ind      = 1'b0;
    addr        = base_val;
    imm_operand = base_val;
    wb_req      = 1'b0;
    wb_val      = base_val;
    case (mode)
      MODE_REG: begin
        needs_mem   = 1'b0;
        imm_operand = base_val;
      end
      MODE_IMM: begin
        needs_mem   = 1'b0;
        imm_operand = konst;
      end
      MODE_DISP:   addr = konst + base_val;
      MODE_RIND:   addr = base_val;
      MODE_INDEX:  addr = base_val + idx_val;
      MODE_ABS:    addr = konst;
      MODE_MIND: begin
        addr   = base_val;
        is_ind = 1'b1;
      end
      MODE_AINC: begin
        addr   = base_val;
        wb_req = 1'b1;
        wb_val = base_val + STEP;
      end
      MODE_ADEC: begin
        addr   = base_val - STEP;
        wb_req = 1'b1;
        wb_val = base_val - STEP;
      end
      MODE_SCALED: addr = konst + base_val + scaled_idx;
      default:     needs_mem = 1'b0;
    endcase
  end

endmodule

// File: rtl/oau_seq.sv
module oau_seq
  import oau_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            mode_ok,
  input  logic            needs_mem,
  input  logic            is_ind,
  input  logic [XLEN-1:0] addr_in,
  input  logic [XLEN-1:0] imm_operand,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_rd_en,
  output logic [XLEN-1:0] mem_addr,
  output logic            accept,
  output logic            fin,
  output logic            fin_direct,
  output logic [XLEN-1:0] fin_operand
);

  seq_state_e      state_q;
  logic            rd_en_q;
  logic            ind_q;
  logic [XLEN-1:0] addr_q;

  assign accept      = start && (state_q == SQ_IDLE) && mode_ok;
  assign fin_direct  = accept && !needs_mem;
  assign fin         = fin_direct || ((state_q == SQ_TAKE) && !ind_q);
  assign fin_operand = fin_direct ? imm_operand : mem_rdata;
  assign mem_rd_en   = rd_en_q;
  assign mem_addr    = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      rd_en_q <= 1'b0;
      ind_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (accept && needs_mem) begin
            rd_en_q <= 1'b1;
            addr_q  <= addr_in;
            ind_q   <= is_ind;
            state_q <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          rd_en_q <= 1'b0;
          state_q <= SQ_TAKE;
        end
        SQ_TAKE: begin
          if (ind_q) begin
            rd_en_q <= 1'b1;
            addr_q  <= mem_rdata;
            ind_q   <= 1'b0;
            state_q <= SQ_WAIT;
          end else begin
            state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R5
  idle_ind_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_IDLE) |-> !ind_q);

endmodule

// File: rtl/oau_result.sv
module oau_result #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic            fin,
  input  logic            fin_direct,
  input  logic [XLEN-1:0] fin_operand,
  input  logic [XLEN-1:0] dst_in,
  input  logic            wb_req,
  input  logic [XLEN-1:0] wb_val,
  output logic            done,
  output logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] result,
  output logic            wb_en,
  output logic [XLEN-1:0] wb_val_out
);

  logic [XLEN-1:0] dst_q;
  logic            wbreq_q;
  logic [XLEN-1:0] wbv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      operand    <= '0;
      result     <= '0;
      wb_en      <= 1'b0;
      wb_val_out <= '0;
      dst_q      <= '0;
      wbreq_q    <= 1'b0;
      wbv_q      <= '0;
    end else begin
      done  <= fin;
      wb_en <= fin && !fin_direct && wbreq_q;
      if (accept) begin
        dst_q   <= dst_in;
        wbreq_q <= wb_req;
        wbv_q   <= wb_val;
      end
      if (fin) begin
        result     <= (fin_direct ? dst_in : dst_q) + fin_operand;
        operand    <= fin_operand;
        wb_val_out <= wbv_q;
      end
    end
  end

endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
  import oau_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ELEM_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [3:0]      mode,
  input  logic [XLEN-1:0] konst,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] idx_val,
  output logic            mem_rd_en,
  output logic [XLEN-1:0] mem_addr,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done,
  output logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] result,
  output logic            base_wr_en,
  output logic [XLEN-1:0] base_wr_val
);

  logic            mode_ok, needs_mem, is_ind, wb_req;
  logic [XLEN-1:0] addr, imm_operand, wb_val;
  logic            accept, fin, fin_direct;
  logic [XLEN-1:0] fin_operand;

  oau_agen #(.XLEN(XLEN), .ELEM_BYTES(ELEM_BYTES)) agen_i (
    .mode        (mode),
    .konst       (konst),
    .base_val    (base_val),
    .idx_val     (idx_val),
    .mode_ok     (mode_ok),
    .needs_mem   (needs_mem),
    .is_ind      (is_ind),
    .addr        (addr),
    .imm_operand (imm_operand),
    .wb_req      (wb_req),
    .wb_val      (wb_val)
  );

  oau_seq #(.XLEN(XLEN)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mode_ok     (mode_ok),
    .needs_mem   (needs_mem),
    .is_ind      (is_ind),
    .addr_in     (addr),
    .imm_operand (imm_operand),
    .mem_rdata   (mem_rdata),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .accept      (accept),
    .fin         (fin),
    .fin_direct  (fin_direct),
    .fin_operand (fin_operand)
  );

  oau_result #(.XLEN(XLEN)) res_i (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .fin         (fin),
    .fin_direct  (fin_direct),
    .fin_operand (fin_operand),
    .dst_in      (dst_val),
    .wb_req      (wb_req),
    .wb_val      (wb_val),
    .done        (done),
    .operand     (operand),
    .result      (result),
    .wb_en       (base_wr_en),
    .wb_val_out  (base_wr_val)
  );

  // R10
  done_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_rd_en);

  // R3
  rd_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !done);

  // R9
  wb_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    base_wr_en |-> done);

endmodule

// File: tb/operand_addr_unit_tb_top.sv
module operand_addr_unit_tb_top;

  localparam int XLEN = 32;
  localparam int EB   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [3:0]      mode = '0;
  logic [XLEN-1:0] konst = '0, dst_val = '0, base_val = '0, idx_val = '0;
  logic            mem_rd_en;
  logic [XLEN-1:0] mem_addr;
  logic [XLEN-1:0] mem_rdata = '0;
  logic            done, base_wr_en;
  logic [XLEN-1:0] operand, result, base_wr_val;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rd_count = 0;
  logic [XLEN-1:0] addr_log [2];

  always #4 clk = ~clk;

  operand_addr_unit #(.XLEN(XLEN), .ELEM_BYTES(EB)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .konst(konst),
    .dst_val(dst_val), .base_val(base_val), .idx_val(idx_val),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .operand(operand), .result(result),
    .base_wr_en(base_wr_en), .base_wr_val(base_wr_val)
  );

  function automatic logic [XLEN-1:0] memf(input logic [XLEN-1:0] a);
    return (a * 32'd2654435761) ^ 32'h1357_9BDF;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= memf(mem_addr);
      if (rd_count < 2) addr_log[rd_count] <= mem_addr;
      rd_count <= rd_count + 1;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected under 50000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Generic runner used by the scenario tasks; exp_lat 0 means no done expected
  task automatic run_op(input string tag, input logic [3:0] m, input logic [XLEN-1:0] k,
                        input logic [XLEN-1:0] d, input logic [XLEN-1:0] b,
                        input logic [XLEN-1:0] i, input int exp_lat, input int exp_nrd,
                        input logic [XLEN-1:0] a0, input logic [XLEN-1:0] a1,
                        input logic [XLEN-1:0] exp_op, input bit exp_wb,
                        input logic [XLEN-1:0] exp_wbv, input int inj_cyc);
    int lat = 0;
    int dcnt = 0;
    int wcnt = 0;
    logic [XLEN-1:0] r_res = '0, r_op = '0, r_wbv = '0;
    bit r_wb = 0;
    @(negedge clk);
    rd_count = 0;
    mode = m; konst = k; dst_val = d; base_val = b; idx_val = i; start = 1'b1;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      if (c == 1) begin
        start = 1'b0;
        mode = 4'd0; konst = 32'hDEAD_BEEF; dst_val = 32'h7777_0000;
        base_val = 32'hCAFE_F00C; idx_val = 32'h0BAD_0BAD;
      end
      if (inj_cyc != 0 && c == inj_cyc) start = 1'b1;
      if (inj_cyc != 0 && c == inj_cyc + 1) start = 1'b0;
      if (done) begin
        dcnt++;
        if (lat == 0) begin
          lat = c; r_res = result; r_op = operand; r_wb = base_wr_en; r_wbv = base_wr_val;
        end
      end
      if (base_wr_en) wcnt++;
    end
    if (exp_lat == 0) begin
      chk(dcnt == 0, {tag, " R12 no done"}, dcnt, 0);
      chk(rd_count == 0, {tag, " R12 no read"}, rd_count, 0);
      return;
    end
    chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
    chk(dcnt == 1, {tag, " R11 single done"}, dcnt, 1);
    chk(rd_count == exp_nrd, {tag, " read count"}, rd_count, exp_nrd);
    if (exp_nrd >= 1) chk(addr_log[0] == a0, {tag, " first address"}, addr_log[0], a0);
    if (exp_nrd >= 2) chk(addr_log[1] == a1, {tag, " second address"}, addr_log[1], a1);
    chk(r_op == exp_op, {tag, " operand"}, r_op, exp_op);
    chk(r_res == d + exp_op, {tag, " R10 R13 result"}, r_res, d + exp_op);
    chk(r_wb == exp_wb && wcnt == (exp_wb ? 1 : 0), {tag, " R9 writeback strobe"},
        XLEN'(wcnt), XLEN'(exp_wb));
    if (exp_wb) chk(r_wbv == exp_wbv, {tag, " writeback value"}, r_wbv, exp_wbv);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R1 done after reset", XLEN'(done), 0);
    chk(mem_rd_en == 1'b0, "R1 rd_en after reset", XLEN'(mem_rd_en), 0);
    chk(base_wr_en == 1'b0, "R1 wr_en after reset", XLEN'(base_wr_en), 0);
  endtask

  task automatic t_reg_imm();
    run_op("R2 reg", 4'd0, 32'h5, 32'd100, 32'd23, 32'd9, 1, 0, 0, 0, 32'd23, 0, 0, 0);
    run_op("R2 imm", 4'd1, 32'hFFFF_FFFD, 32'd5, 32'd77, 32'd9, 1, 0, 0, 0,
           32'hFFFF_FFFD, 0, 0, 0);
  endtask

  task automatic t_single();
    run_op("R4 disp", 4'd2, 32'h100, 32'd1, 32'h2000, 32'h0, 3, 1, 32'h2100, 0,
           memf(32'h2100), 0, 0, 0);
    run_op("R4 rind", 4'd3, 32'h999, 32'd2, 32'h3004, 32'h8, 3, 1, 32'h3004, 0,
           memf(32'h3004), 0, 0, 0);
    run_op("R4 index", 4'd4, 32'h999, 32'd3, 32'h1000, 32'h24, 3, 1, 32'h1024, 0,
           memf(32'h1024), 0, 0, 0);
    run_op("R3 R4 abs", 4'd5, 32'h1001, 32'd4, 32'h50, 32'h8, 3, 1, 32'h1001, 0,
           memf(32'h1001), 0, 0, 0);
  endtask

  task automatic t_indirect();
    logic [XLEN-1:0] p = memf(32'h40);
    run_op("R5 mind", 4'd6, 32'h0, 32'd10, 32'h40, 32'h0, 5, 2, 32'h40, p,
           memf(p), 0, 0, 0);
  endtask

  task automatic t_auto();
    run_op("R6 ainc", 4'd7, 32'h0, 32'd6, 32'h500, 32'h0, 3, 1, 32'h500, 0,
           memf(32'h500), 1, 32'h500 + EB, 0);
    run_op("R7 adec", 4'd8, 32'h0, 32'd7, 32'h500, 32'h0, 3, 1, 32'h500 - EB, 0,
           memf(32'h500 - EB), 1, 32'h500 - EB, 0);
    run_op("R7 adec wrap", 4'd8, 32'h0, 32'd7, 32'h2, 32'h0, 3, 1, 32'hFFFF_FFFE, 0,
           memf(32'hFFFF_FFFE), 1, 32'hFFFF_FFFE, 0);
  endtask

  task automatic t_scaled();
    logic [XLEN-1:0] a = 32'd100 + 32'h1000 + 32'd3 * EB;
    run_op("R8 scaled", 4'd9, 32'd100, 32'd8, 32'h1000, 32'd3, 3, 1, a, 0, memf(a), 0, 0, 0);
  endtask

  task automatic t_busy();
    logic [XLEN-1:0] p = memf(32'h88);
    run_op("R11 busy mind", 4'd6, 32'h0, 32'd11, 32'h88, 32'h0, 5, 2, 32'h88, p,
           memf(p), 0, 0, 2);
  endtask

  task automatic t_reserved();
    run_op("R12 code10", 4'd10, 32'h10, 32'd1, 32'h400, 32'h1, 0, 0, 0, 0, 0, 0, 0, 0);
    run_op("R12 code15", 4'd15, 32'h10, 32'd1, 32'h400, 32'h1, 0, 0, 0, 0, 0, 0, 0, 0);
    run_op("R12 idle after", 4'd0, 32'h0, 32'd40, 32'd2, 32'h0, 1, 0, 0, 0, 32'd2, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reg_imm();
    t_single();
    t_indirect();
    t_auto();
    t_scaled();
    t_busy();
    t_reserved();
    finish_run();
  end

endmodule